// File: doc/BRIEF.md
# Bus Master Burst Request Engine

This block is the user-side master logic that sits behind a generic bus-attachment wrapper and starts read or write bursts on the host bus. A local client hands it one command at a time. Each command carries a direction, a host address, byte enables, a coded burst length, a lock request and a starting index into a local buffer. The engine then raises a master request toward the wrapper and holds every request field steady until the transaction completes.

The wrapper answers with one-cycle per-beat acknowledges. On the final beat a last-beat acknowledge arrives in the same cycle. Instead of finishing, the wrapper can end the transaction with one of three one-cycle outcomes: retry, timeout or error. Each acknowledged beat moves the local buffer index forward by one. For a write this index names the source word, and for a read it names the destination word.

A retry drops the request for one cycle, rewinds the buffer index and issues the same burst again. Once a configurable number of reissues has been used up, a further retry ends the command as a failure. A timeout or an error ends the command at once. When a command finishes, the engine gives a one-cycle done pulse together with a status code and the number of beats transferred.

Top module: `burst_master_engine`

## Requirements
- R1: While reset is held and right after it, `mst_req`, `mst_lock` and `done_pulse` are 0, `cmd_ready` is 1, `mst_addr` is 0 and `mst_local_addr` is 0.
- R2: When `cmd_valid` is high while `cmd_ready` is high, then in the next cycle `mst_req` is 1. In that cycle `mst_addr`, `mst_be`, `mst_rnw` (1 = read, 0 = write) and `mst_num` carry the command values, with `mst_num` equal to the transfer count minus one (0 = one beat, 15 = sixteen). `mst_burst` is 1 only when `mst_num` is nonzero. All of these stay stable while the request is held. `mst_addr` is 0 whenever `mst_req` is 0.
- R3: `mst_local_addr` is loaded with `cmd_local` when a command is accepted. It advances by one (modulo 2^LAW) on each cycle in which `beat_ack` is high while `mst_req` is high. A `beat_ack` seen while `mst_req` is low has no effect.
- R4: `mst_req` is 0 in the cycle after any cycle in which `mst_req` was high and one of `last_ack`, `retry_in`, `tout_in` or `err_in` was high.
- R5: After `last_ack`, which arrives together with the final `beat_ack`, `done_pulse` is high for exactly one cycle, in the following cycle. In that cycle `done_status` is 0 and `done_beats` equals the number of beats acknowledged. One cycle after the pulse, `cmd_ready` returns to 1.
- R6: On a retry that is within the limit, `mst_req` is 0 for one cycle and then returns with identical fields. In the cycle the request is low, `mst_local_addr` is back at the command's start value, and the beat count restarts.
- R7: A retry that arrives after RETRY_MAX reissues ends the command with `done_status` = 1, `done_beats` = 0 and `mst_local_addr` at the start value.
- R8: A timeout ends the command with `done_status` = 2, and an error ends it with `done_status` = 3. Neither causes a reissue. `done_beats` counts the beats acknowledged before the outcome.
- R9: When the command's lock bit is set, `mst_lock` is 1 from the first request cycle through the last request cycle, including the one-cycle gaps between reissues, and drops only as `done_pulse` rises. When the lock bit is clear, `mst_lock` stays 0.
- R10: A `cmd_valid` pulse while `cmd_ready` is 0 is ignored, and the fields of the burst in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command |
| cmd_ready | output | 1 | Engine idle, command may be accepted |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | AW | Host address |
| cmd_be | input | BEW | Byte enables |
| cmd_len | input | LENW | Transfer count minus one |
| cmd_lock | input | 1 | Keep the host bus locked for this command |
| cmd_local | input | LAW | Starting local buffer index |
| mst_req | output | 1 | Master request to the wrapper |
| mst_rnw | output | 1 | Direction of the request |
| mst_addr | output | AW | Host address, zero when no request |
| mst_be | output | BEW | Byte enables of the request |
| mst_burst | output | 1 | Request is a multi-beat burst |
| mst_num | output | LENW | Coded burst length |
| mst_lock | output | 1 | Bus lock request |
| mst_local_addr | output | LAW | Current local buffer index |
| beat_ack | input | 1 | One-cycle per-beat acknowledge |
| last_ack | input | 1 | One-cycle final acknowledge, with the final beat |
| retry_in | input | 1 | One-cycle retry completion |
| tout_in | input | 1 | One-cycle timeout completion |
| err_in | input | 1 | One-cycle error completion |
| done_pulse | output | 1 | One-cycle command completion |
| done_status | output | 2 | 0 ok, 1 retries exhausted, 2 timeout, 3 error |
| done_beats | output | LENW+1 | Beats acknowledged in the final attempt |

## Verification
The bench covers the single-beat and sixteen-beat extremes of the length code, because an off-by-one in the minus-one coding would show up there as a wrong `mst_burst` flag or a wrong beat total. It sends retries at random points within a burst and checks the rewind. A design that did not rewind `mst_local_addr` would leave the next attempt writing past the buffer. The final retry that exhausts the limit is aimed at one exact count, so a limit that is off by one either reissues once too often or gives up one attempt early. Acknowledges sent while the engine is idle and new commands sent while it is busy both target designs that act on stimulus they should ignore. The lock line is followed across the reissue gaps, where a design that ties lock to the request would briefly release the bus.

// File: rtl/burst_master_engine.sv
module burst_master_engine #(
  parameter int AW        = 32,
  parameter int BEW       = 4,
  parameter int LAW       = 8,
  parameter int LENW      = 4,
  parameter int RETRY_MAX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic            cmd_rd,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [BEW-1:0]  cmd_be,
  input  logic [LENW-1:0] cmd_len,
  input  logic            cmd_lock,
  input  logic [LAW-1:0]  cmd_local,
  output logic            mst_req,
  output logic            mst_rnw,
  output logic [AW-1:0]   mst_addr,
  output logic [BEW-1:0]  mst_be,
  output logic            mst_burst,
  output logic [LENW-1:0] mst_num,
  output logic            mst_lock,
  output logic [LAW-1:0]  mst_local_addr,
  input  logic            beat_ack,
  input  logic            last_ack,
  input  logic            retry_in,
  input  logic            tout_in,
  input  logic            err_in,
  output logic            done_pulse,
  output logic [1:0]      done_status,
  output logic [LENW:0]   done_beats
);

  localparam int RCW = $clog2(RETRY_MAX + 2);
  localparam int BCW = LENW + 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_DATA, S_GAP, S_DONE} state_t;

  state_t          st;
  logic            rd_q, lk_q;
  logic [AW-1:0]   addr_q;
  logic [BEW-1:0]  be_q;
  logic [LENW-1:0] len_q;
  logic [LAW-1:0]  base_q, ptr_q;
  logic [BCW-1:0]  beats_q;
  logic [RCW-1:0]  tries_q;
  logic [1:0]      stat_q;

  wire active = (st == S_REQ) || (st == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rd_q    <= 1'b0;
      lk_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      len_q   <= '0;
      base_q  <= '0;
      ptr_q   <= '0;
      beats_q <= '0;
      tries_q <= '0;
      stat_q  <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          rd_q    <= cmd_rd;
          lk_q    <= cmd_lock;
          addr_q  <= cmd_addr;
          be_q    <= cmd_be;
          len_q   <= cmd_len;
          base_q  <= cmd_local;
          ptr_q   <= cmd_local;
          beats_q <= '0;
          tries_q <= '0;
          st      <= S_REQ;
        end
        S_REQ, S_DATA: begin
          if (err_in) begin
            stat_q <= 2'd3;
            st     <= S_DONE;
          end else if (tout_in) begin
            stat_q <= 2'd2;
            st     <= S_DONE;
          end else if (retry_in) begin
            ptr_q   <= base_q;
            beats_q <= '0;
            if (tries_q == RCW'(RETRY_MAX)) begin
              stat_q <= 2'd1;
              st     <= S_DONE;
            end else begin
              tries_q <= tries_q + 1'b1;
              st      <= S_GAP;
            end
          end else begin
            if (beat_ack) begin
              ptr_q   <= ptr_q + 1'b1;
              beats_q <= beats_q + 1'b1;
            end
            if (last_ack) begin
              stat_q <= 2'd0;
              st     <= S_DONE;
            end else begin
              st <= S_DATA;
            end
          end
        end
        S_GAP:   st <= S_REQ;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready      = (st == S_IDLE);
  assign mst_req        = active;
  assign mst_rnw        = rd_q;
  assign mst_addr       = active ? addr_q : '0;
  assign mst_be         = be_q;
  assign mst_num        = len_q;
  assign mst_burst      = active && (len_q != '0);
  assign mst_lock       = lk_q && (active || st == S_GAP);
  assign mst_local_addr = ptr_q;
  assign done_pulse     = (st == S_DONE);
  assign done_status    = stat_q;
  assign done_beats     = beats_q;

endmodule

// File: rtl/burst_master_engine_chk.sv
module burst_master_engine_chk #(
  parameter int AW   = 32,
  parameter int LAW  = 8,
  parameter int LENW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mst_req,
  input logic            mst_lock,
  input logic            mst_rnw,
  input logic [AW-1:0]   mst_addr,
  input logic [LENW-1:0] mst_num,
  input logic [LAW-1:0]  mst_local_addr,
  input logic            beat_ack,
  input logic            last_ack,
  input logic            retry_in,
  input logic            tout_in,
  input logic            err_in,
  input logic            done_pulse
);

  wire fin = last_ack || retry_in || tout_in || err_in;

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !fin) |=> (mst_req && $stable(mst_addr) && $stable(mst_num) && $stable(mst_rnw))); // R2

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && !beat_ack && !retry_in) |=> $stable(mst_local_addr)); // R3

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && fin) |=> !mst_req); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse); // R5

  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_lock) |-> done_pulse); // R9

endmodule

bind burst_master_engine burst_master_engine_chk #(.AW(AW), .LAW(LAW), .LENW(LENW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_lock(mst_lock), .mst_rnw(mst_rnw),
  .mst_addr(mst_addr), .mst_num(mst_num), .mst_local_addr(mst_local_addr),
  .beat_ack(beat_ack), .last_ack(last_ack), .retry_in(retry_in), .tout_in(tout_in),
  .err_in(err_in), .done_pulse(done_pulse)
);

// File: tb/burst_master_engine_tb.sv
module burst_master_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, BEW = 4, LAW = 8, LENW = 4, RETRY_MAX = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rd = 1'b0, cmd_lock = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [BEW-1:0] cmd_be = '0;
  logic [LENW-1:0] cmd_len = '0;
  logic [LAW-1:0] cmd_local = '0;
  logic beat_ack = 1'b0, last_ack = 1'b0, retry_in = 1'b0, tout_in = 1'b0, err_in = 1'b0;
  logic cmd_ready, mst_req, mst_rnw, mst_burst, mst_lock, done_pulse;
  logic [AW-1:0] mst_addr;
  logic [BEW-1:0] mst_be;
  logic [LENW-1:0] mst_num;
  logic [LAW-1:0] mst_local_addr;
  logic [1:0] done_status;
  logic [LENW:0] done_beats;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_master_engine #(.AW(AW), .BEW(BEW), .LAW(LAW), .LENW(LENW), .RETRY_MAX(RETRY_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_len(cmd_len), .cmd_lock(cmd_lock),
    .cmd_local(cmd_local), .mst_req(mst_req), .mst_rnw(mst_rnw), .mst_addr(mst_addr),
    .mst_be(mst_be), .mst_burst(mst_burst), .mst_num(mst_num), .mst_lock(mst_lock),
    .mst_local_addr(mst_local_addr), .beat_ack(beat_ack), .last_ack(last_ack),
    .retry_in(retry_in), .tout_in(tout_in), .err_in(err_in), .done_pulse(done_pulse),
    .done_status(done_status), .done_beats(done_beats)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_status(input int nretry, input int kind);
    if (nretry > RETRY_MAX) return 1;
    return (kind == 0) ? 0 : (kind == 1) ? 2 : 3;
  endfunction

  function automatic int exp_ptr(input int start, input int beats);
    return (start + beats) % (1 << LAW);
  endfunction

  // kind: 0 finish normally, 1 timeout, 2 error; nretry retries precede it
  task automatic run_txn(input bit rd, input int len, input bit lk, input int loc,
                         input int nretry, input int kind);
    logic [AW-1:0] a = AW'($urandom);
    logic [BEW-1:0] be = BEW'($urandom);
    int cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_addr = a; cmd_be = be;
    cmd_len = LENW'(len); cmd_lock = lk; cmd_local = LAW'(loc);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 req", 64'(mst_req), 1);
    chk("R2 addr", 64'(mst_addr), 64'(a));
    chk("R2 be", 64'(mst_be), 64'(be));
    chk("R2 rnw", 64'(mst_rnw), 64'(rd));
    chk("R2 num", 64'(mst_num), len);
    chk("R2 burst", 64'(mst_burst), (len != 0) ? 1 : 0);
    chk("R9 lock", 64'(mst_lock), 64'(lk));
    chk("R3 start", 64'(mst_local_addr), loc);
    for (int at = 0; at <= RETRY_MAX + 1; at++) begin
      bit is_retry = (at < nretry);
      int nb;
      int wt = $urandom_range(0, 2);
      for (int w = 0; w < wt; w++) begin
        cmd_valid = 1'b1; cmd_addr = ~a;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R10 busy", 64'(mst_addr), 64'(a));
        chk("R10 held", 64'(mst_req), 1);
      end
      if (is_retry || kind != 0) nb = $urandom_range(0, len);
      else nb = len + 1;
      for (int b = 0; b < nb; b++) begin
        beat_ack = 1'b1;
        last_ack = (!is_retry && kind == 0 && b == nb - 1);
        @(negedge clk);
        beat_ack = 1'b0; last_ack = 1'b0;
        cnt++;
        chk("R3 step", 64'(mst_local_addr), exp_ptr(loc, cnt));
      end
      if (is_retry) retry_in = 1'b1;
      else if (kind == 1) tout_in = 1'b1;
      else if (kind == 2) err_in = 1'b1;
      if (is_retry || kind != 0) begin
        @(negedge clk);
        retry_in = 1'b0; tout_in = 1'b0; err_in = 1'b0;
      end
      chk("R4 drop", 64'(mst_req), 0);
      if (is_retry && at < RETRY_MAX) begin
        chk("R6 rewind", 64'(mst_local_addr), loc);
        chk("R6 no done", 64'(done_pulse), 0);
        chk("R9 gap lock", 64'(mst_lock), 64'(lk));
        @(negedge clk);
        chk("R6 reissue", 64'(mst_req), 1);
        chk("R6 same addr", 64'(mst_addr), 64'(a));
        chk("R6 same num", 64'(mst_num), len);
        cnt = 0;
      end else begin
        int es = exp_status(nretry, kind);
        int eb = (es == 1) ? 0 : cnt;
        chk("R5 done", 64'(done_pulse), 1);
        chk((es == 1) ? "R7 status" : (es == 0) ? "R5 status" : "R8 status",
            64'(done_status), es);
        chk((es == 1) ? "R7 beats" : "R8 beats", 64'(done_beats), eb);
        chk("R9 released", 64'(mst_lock), 0);
        chk("R3 final", 64'(mst_local_addr), exp_ptr(loc, eb));
        @(negedge clk);
        chk("R5 pulse end", 64'(done_pulse), 0);
        chk("R5 ready", 64'(cmd_ready), 1);
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1b3c5e7));
    repeat (3) @(negedge clk);
    chk("R1 req", 64'(mst_req), 0);
    chk("R1 ready", 64'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 lock", 64'(mst_lock), 0);
    chk("R1 done", 64'(done_pulse), 0);
    chk("R1 addr", 64'(mst_addr), 0);
    chk("R1 local", 64'(mst_local_addr), 0);
    // acknowledges while idle are ignored
    beat_ack = 1'b1; last_ack = 1'b1;
    @(negedge clk);
    beat_ack = 1'b0; last_ack = 1'b0;
    chk("R3 idle ack", 64'(mst_local_addr), 0);
    chk("R3 idle done", 64'(done_pulse), 0);
    run_txn(1'b1, 0, 1'b0, 10, 0, 0);          // single beat
    run_txn(1'b0, 15, 1'b1, 250, 0, 0);        // sixteen beats, wraps local index
    run_txn(1'b1, 7, 1'b1, 40, RETRY_MAX + 1, 0); // retries exhausted
    run_txn(1'b0, 3, 1'b1, 60, 1, 0);          // one retry then success
    run_txn(1'b1, 5, 1'b0, 80, 0, 1);          // timeout
    run_txn(1'b0, 5, 1'b1, 90, 0, 2);          // error
    run_txn(1'b1, 2, 1'b0, 5, RETRY_MAX, 1);   // retries at limit then timeout
    for (int i = 0; i < 40; i++)
      run_txn(1'($urandom), $urandom_range(0, 15), 1'($urandom), $urandom_range(0, 255),
              $urandom_range(0, RETRY_MAX + 1), $urandom_range(0, 2));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule